// File: doc/BRIEF.md
# Serial EEPROM Page-Write Command Controller

This block is the slave-side engine for the write command of a small serial EEPROM attached to an SPI bus run in mode 0. The chip-select, serial-clock and serial-data pins are brought into the system clock domain, and edges are found there. An instruction byte is decoded first. It carries the top address bit. An address byte follows. After that, any number of data bytes are collected into a one-page staging buffer. The write position advances inside the 16-byte page and wraps back to the start of that page.

When chip select is released, the controller decides whether the write goes ahead. It commits only when the release falls on a whole byte and at least one data byte has arrived. Four further conditions must also hold: the write-enable latch input is set, no write cycle is in progress, the write-protect pin is high, and the addressed page is outside the block-protected region. An accepted command copies only the staged bytes into the internal byte array. It then holds the busy flag for a fixed number of system clocks. When the cycle ends, the controller sends a one-cycle request to clear the external write-enable latch. The serial output is never driven. A combinational lookup port exposes the array contents to the surrounding logic.

Top module: `eeprom_write_ctrl`

## Requirements
- R1: After reset `wip` and `welClear` are 0 and every array byte reads 0.
- R2: Only an instruction byte of the form 0000_x010 (bit 3 = x) opens a write. Any other instruction byte makes the rest of the selection have no effect on the array, `wip` or `welClear`.
- R3: Bits are taken MSB first on rising serial clock edges while chip select is low. The target address is {instruction bit 3, address byte} cut down to ADDR_W bits.
- R4: Successive data bytes go to successive addresses within one 16-byte page (address bits [3:0] increment modulo 16, upper bits fixed). A later byte that wraps onto an earlier slot replaces it.
- R5: A command commits only if chip select rises after a whole number of data bytes, with at least one data byte. A partial byte or an empty data phase leaves the array and `wip` unchanged.
- R6: A command is refused when `wel` is 0 or `wpN` is 0 at the moment chip select rises.
- R7: A command ending while `wip` is 1 is refused.
- R8: `bp` = 00 protects nothing, 01 protects the addresses whose two top bits are 11, 10 protects those whose top bit is 1, and 11 protects the whole array. A write whose address is protected is refused.
- R9: An accepted command raises `wip` within 8 clocks of the chip select rise and holds it for exactly TWC clocks. The staged bytes are in the array by the time `wip` falls, and bytes of the page that were not received are unchanged.
- R10: `welClear` pulses for one clock in the cycle after `wip` falls, once per accepted command.
- R11: `sdoOe` is 0 at all times.
- R12: Serial clock and data activity while chip select is high has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock (mode 0) |
| mosi | input | 1 | SPI serial data into the device |
| wpN | input | 1 | Write-protect pin, low blocks writes |
| wel | input | 1 | Write-enable latch state |
| bp | input | 2 | Block-protect selection |
| wip | output | 1 | Write cycle in progress |
| welClear | output | 1 | One-clock request to clear the write-enable latch |
| sdoOe | output | 1 | Serial output drive enable, held 0 |
| rdAddr | input | ADDR_W | Array lookup address |
| rdData | output | 8 | Array byte at `rdAddr` |

## Verification
The hardest case to reach is a command that is perfectly formed but ends while a previous write cycle is still timing out. TWC is set long enough in the bench that a complete second transaction fits inside the busy window. A directed case sends that second transaction straight after an accepted one, so the refusal can be seen in the untouched target page. Wrap-around replacement inside a page is reached with a directed run of more than 16 bytes. Random transactions add odd start offsets, partial final bytes and mixed protection settings.

// File: rtl/ewc_pkg.sv
package ewc_pkg;

  typedef struct packed {
    logic shiftBit;
    logic takeOp;
    logic takeAddr;
    logic takeData;
    logic clearBuf;
    logic commit;
  } ctlStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OP,
    ST_ADDR,
    ST_DATA,
    ST_SKIP
  } ctlState_t;

  function automatic logic isProtected(input logic [1:0] topBits, input logic [1:0] bpSel);
    case (bpSel)
      2'b00:   return 1'b0;
      2'b01:   return topBits == 2'b11;
      2'b10:   return topBits[1];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic opcodeIsWrite(input logic [7:0] op);
    return (op[7:4] == 4'b0000) && (op[2:0] == 3'b010);
  endfunction

endpackage

// File: rtl/ewc_sync.sv
module ewc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic csNIn,
  input  logic sckIn,
  input  logic mosiIn,
  output logic csLow,
  output logic csRise,
  output logic csFall,
  output logic sckRise,
  output logic mosiS
);

  logic [STAGES-1:0] csPipe;
  logic [STAGES-1:0] sckPipe;
  logic [STAGES-1:0] mosiPipe;
  logic              csLast;
  logic              sckLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPipe   <= '1;
      sckPipe  <= '0;
      mosiPipe <= '0;
      csLast   <= 1'b1;
      sckLast  <= 1'b0;
    end else begin
      csPipe   <= {csPipe[STAGES-2:0], csNIn};
      sckPipe  <= {sckPipe[STAGES-2:0], sckIn};
      mosiPipe <= {mosiPipe[STAGES-2:0], mosiIn};
      csLast   <= csPipe[STAGES-1];
      sckLast  <= sckPipe[STAGES-1];
    end
  end

  assign csLow   = ~csPipe[STAGES-1];
  assign csRise  = csPipe[STAGES-1] & ~csLast;
  assign csFall  = ~csPipe[STAGES-1] & csLast;
  assign sckRise = sckPipe[STAGES-1] & ~sckLast;
  assign mosiS   = mosiPipe[STAGES-1];

endmodule

// File: rtl/ewc_ctrl.sv
module ewc_ctrl
  import ewc_pkg::*;
#(
  parameter int TWC = 1000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csLow,
  input  logic        csRise,
  input  logic        csFall,
  input  logic        sckRise,
  input  logic [7:0]  curByte,
  input  logic        wel,
  input  logic        wpN,
  input  logic        addrProtected,
  output ctlStrobes_t strb,
  output logic        wip,
  output logic        welClear
);

  localparam int TMR_W = $clog2(TWC + 1);

  ctlState_t  state;
  logic [2:0] bitCnt;
  logic       gotData;
  logic [TMR_W-1:0] timer;
  logic       byteDone;
  logic       gatesOpen;

  assign byteDone  = strb.shiftBit && (bitCnt == 3'd7);
  assign gatesOpen = wel && wpN && !addrProtected && !wip;

  always_comb begin
    strb          = '0;
    strb.shiftBit = sckRise && csLow && (state != ST_IDLE);
    strb.takeOp   = byteDone && (state == ST_OP) && opcodeIsWrite(curByte);
    strb.takeAddr = byteDone && (state == ST_ADDR);
    strb.takeData = byteDone && (state == ST_DATA);
    strb.clearBuf = csFall;
    strb.commit   = csRise && (state == ST_DATA) && (bitCnt == 3'd0)
                    && gotData && gatesOpen;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      gotData <= 1'b0;
    end else if (csFall) begin
      state   <= ST_OP;
      bitCnt  <= '0;
      gotData <= 1'b0;
    end else if (csRise) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
    end else if (strb.shiftBit) begin
      bitCnt <= bitCnt + 3'd1;
      if (byteDone) begin
        case (state)
          ST_OP:   state <= opcodeIsWrite(curByte) ? ST_ADDR : ST_SKIP;
          ST_ADDR: state <= ST_DATA;
          ST_DATA: gotData <= 1'b1;
          default: state <= state;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wip      <= 1'b0;
      welClear <= 1'b0;
      timer    <= '0;
    end else begin
      welClear <= 1'b0;
      if (strb.commit) begin
        wip   <= 1'b1;
        timer <= TMR_W'(TWC - 1);
      end else if (wip) begin
        if (timer == '0) begin
          wip      <= 1'b0;
          welClear <= 1'b1;
        end else begin
          timer <= timer - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/ewc_datapath.sv
module ewc_datapath
  import ewc_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic              mosiS,
  input  logic [1:0]        bp,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        curByte,
  output logic              addrProtected,
  output logic [7:0]        rdData
);

  localparam int DEPTH   = 1 << ADDR_W;
  localparam int PAGE_SZ = 1 << PAGE_W;
  localparam int PNUM_W  = ADDR_W - PAGE_W;

  logic [7:0]         shReg;
  logic               topBit;
  logic [ADDR_W-1:0]  addrReg;
  logic [PAGE_W-1:0]  wrPtr;
  logic [7:0]         pageBuf [PAGE_SZ];
  logic [PAGE_SZ-1:0] validMask;
  logic [7:0]         mem [DEPTH];
  logic [8:0]         fullAddr;
  logic [PNUM_W-1:0]  pageNum;

  assign curByte  = {shReg[6:0], mosiS};
  assign fullAddr = {topBit, curByte};
  assign pageNum  = addrReg[ADDR_W-1:PAGE_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg   <= '0;
      topBit  <= 1'b0;
      addrReg <= '0;
      wrPtr   <= '0;
    end else begin
      if (strb.shiftBit) shReg <= curByte;
      if (strb.takeOp) topBit <= curByte[3];
      if (strb.takeAddr) begin
        addrReg <= fullAddr[ADDR_W-1:0];
        wrPtr   <= curByte[PAGE_W-1:0];
      end
      if (strb.takeData) wrPtr <= wrPtr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validMask <= '0;
      for (int i = 0; i < PAGE_SZ; i++) pageBuf[i] <= '0;
    end else if (strb.clearBuf) begin
      validMask <= '0;
    end else if (strb.takeData) begin
      pageBuf[wrPtr]   <= curByte;
      validMask[wrPtr] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int j = 0; j < DEPTH; j++) mem[j] <= '0;
    end else if (strb.commit) begin
      for (int k = 0; k < PAGE_SZ; k++) begin
        if (validMask[k]) mem[{pageNum, PAGE_W'(k)}] <= pageBuf[k];
      end
    end
  end

  assign addrProtected = isProtected(addrReg[ADDR_W-1 -: 2], bp);
  assign rdData        = mem[rdAddr];

endmodule

// File: rtl/eeprom_write_ctrl.sv
module eeprom_write_ctrl
  import ewc_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int PAGE_W = 4,
  parameter int TWC    = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sck,
  input  logic              mosi,
  input  logic              wpN,
  input  logic              wel,
  input  logic [1:0]        bp,
  output logic              wip,
  output logic              welClear,
  output logic              sdoOe,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData
);

  logic        csLow, csRise, csFall, sckRise, mosiS;
  logic [7:0]  curByte;
  logic        addrProtected;
  ctlStrobes_t strb;
  logic        commitStrb;

  assign commitStrb = strb.commit;
  assign sdoOe      = 1'b0;

  ewc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .csNIn(csN), .sckIn(sck), .mosiIn(mosi),
    .csLow(csLow), .csRise(csRise), .csFall(csFall),
    .sckRise(sckRise), .mosiS(mosiS)
  );

  ewc_ctrl #(.TWC(TWC)) u_ctrl (
    .clk(clk), .rstN(rstN), .csLow(csLow), .csRise(csRise),
    .csFall(csFall), .sckRise(sckRise), .curByte(curByte),
    .wel(wel), .wpN(wpN), .addrProtected(addrProtected),
    .strb(strb), .wip(wip), .welClear(welClear)
  );

  ewc_datapath #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .mosiS(mosiS), .bp(bp),
    .rdAddr(rdAddr), .curByte(curByte),
    .addrProtected(addrProtected), .rdData(rdData)
  );

endmodule

// File: rtl/ewc_chk.sv
module ewc_chk #(
  parameter int TWC = 1000
) (
  input logic clk,
  input logic rstN,
  input logic wip,
  input logic welClear,
  input logic sdoOe,
  input logic commit,
  input logic wel,
  input logic wpN
);

  int unsigned runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runLen <= 0;
    else if (wip) runLen <= runLen + 1;
    else runLen <= 0;
  end

  // R11
  sdo_idle_chk: assert property (@(posedge clk) disable iff (!rstN) !sdoOe);

  // R10
  wel_clear_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    welClear |-> $fell(wip));

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wip) |-> $past(commit));

  // R9
  busy_length_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wip) |-> runLen == TWC);

  // R9
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    wip |-> runLen < TWC);

  // R7
  no_commit_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    commit |=> $rose(wip));

  // R6
  commit_gates_chk: assert property (@(posedge clk) disable iff (!rstN)
    commit |-> (wel && wpN));

endmodule

bind eeprom_write_ctrl ewc_chk #(.TWC(TWC)) u_chk (
  .clk(clk), .rstN(rstN), .wip(wip), .welClear(welClear), .sdoOe(sdoOe),
  .commit(commitStrb), .wel(wel), .wpN(wpN)
);

// File: tb/eeprom_write_ctrl_tb.sv
module eeprom_write_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TWC        = 600;
  localparam int HALF       = 4;

  logic       clk = 0;
  logic       rstN = 0;
  logic       csN = 1, sck = 0, mosi = 0, wpN = 1, wel = 0;
  logic [1:0] bp = 0;
  logic       wip, welClear, sdoOe;
  logic [8:0] rdAddr = 0;
  logic [7:0] rdData;

  int checks = 0, errors = 0;
  int welCount = 0, welExpect = 0;
  int runLen = 0, lastRun = 0;
  int cycles = 0;
  logic [7:0] model [512];

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_write_ctrl #(.TWC(TWC)) u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .mosi(mosi),
    .wpN(wpN), .wel(wel), .bp(bp), .wip(wip), .welClear(welClear),
    .sdoOe(sdoOe), .rdAddr(rdAddr), .rdData(rdData)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rstN && welClear) welCount <= welCount + 1;
    if (rstN && wip) runLen <= runLen + 1;
    else begin
      if (runLen != 0) lastRun <= runLen;
      runLen <= 0;
    end
    if (rstN && sdoOe) begin
      errors <= errors + 1;
      $display("FAIL R11 sdoOe actual=1 expected=0");
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic b);
    mosi = b; clks(HALF); sck = 1; clks(HALF); sck = 0;
  endtask

  task automatic sendByte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
  endtask

  function automatic logic protBench(input logic [8:0] a, input logic [1:0] p);
    return (p == 2'd3) || (p == 2'd2 && a[8]) || (p == 2'd1 && a[8:7] == 2'b11);
  endfunction

  task automatic comparePage(input string req, input logic [8:0] a);
    for (int i = 0; i < 16; i++) begin
      rdAddr = {a[8:4], 4'(i)};
      #1;
      check(req, rdData, model[{a[8:4], 4'(i)}]);
    end
  endtask

  task automatic waitIdle(input string req);
    int t = 0;
    while (wip && t < TWC + 50) begin clks(1); t++; end
    clks(3);
    check(req, wip, 0);
    check("R9 busy length", lastRun, TWC);
    check("R10 welClear count", welCount, welExpect);
    wel = 0;
  endtask

  // n data bytes, then 'extra' stray bits before release
  task automatic runTxn(input string req, input logic [7:0] op, input logic [7:0] ab,
                        input int n, input int extra, input bit noWait);
    logic [8:0] a;
    logic [7:0] d [32];
    bit acc;
    a = {op[3], ab};
    acc = (op[7:4] == 0) && (op[2:0] == 3'b010) && n >= 1 && extra == 0 &&
          wel && wpN && !protBench(a, bp) && !wip;
    for (int i = 0; i < n; i++) d[i] = 8'($urandom);
    csN = 0; clks(HALF);
    sendByte(op);
    sendByte(ab);
    for (int i = 0; i < n; i++) sendByte(d[i]);
    for (int i = 0; i < extra; i++) sendBit(1'($urandom));
    clks(HALF); csN = 1; clks(8);
    if (acc) begin
      for (int i = 0; i < n; i++) model[{a[8:4], 4'(a[3:0] + 4'(i))}] = d[i];
      welExpect++;
      check({req, " R9 wip raised"}, wip, 1);
      if (!noWait) waitIdle(req);
    end else if (!noWait) begin
      if (wip) waitIdle(req);
      check({req, " wip stays low"}, wip, 0);
    end
    if (!noWait) comparePage(req, a);
  endtask

  initial begin
    clks(190000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 512; i++) model[i] = 0;
    clks(4); rstN = 1; clks(2);

    // R1 reset state
    check("R1 wip", wip, 0);
    check("R1 welClear", welClear, 0);
    check("R11 sdoOe", sdoOe, 0);
    comparePage("R1 array", 9'h000);
    comparePage("R1 array", 9'h1F0);

    // R3 A8 from instruction bit 3, single byte
    wel = 1; runTxn("R3", 8'h0A, 8'h25, 1, 0, 0);
    // R4 wrap within page with overwrite
    wel = 1; runTxn("R4", 8'h02, 8'h4E, 19, 0, 0);
    // R5 partial byte and empty data phase
    wel = 1; runTxn("R5 partial", 8'h02, 8'h60, 2, 3, 0);
    runTxn("R5 empty", 8'h02, 8'h60, 0, 0, 0);
    // R6 latch clear and write-protect pin
    wel = 0; runTxn("R6 wel", 8'h02, 8'h70, 2, 0, 0);
    wel = 1; wpN = 0; runTxn("R6 wpN", 8'h02, 8'h70, 2, 0, 0); wpN = 1;
    // R8 block protect
    bp = 2'b01; runTxn("R8 upper quarter", 8'h0A, 8'hC4, 2, 0, 0);
    runTxn("R8 below quarter", 8'h0A, 8'h04, 2, 0, 0);
    wel = 1; bp = 2'b10; runTxn("R8 upper half", 8'h0A, 8'h10, 2, 0, 0);
    bp = 2'b11; runTxn("R8 all", 8'h02, 8'h10, 2, 0, 0); bp = 0;
    // R2 bad opcode
    runTxn("R2 bad op", 8'h42, 8'h80, 3, 0, 0);
    runTxn("R2 read-like op", 8'h03, 8'h80, 3, 0, 0);
    // R7 second command while busy
    wel = 1; runTxn("R7 first", 8'h02, 8'hA0, 3, 0, 1);
    runTxn("R7 during busy", 8'h02, 8'hB0, 3, 0, 0);
    comparePage("R7 first page", 9'h0A0);
    // R12 sck activity with chip select high
    for (int i = 0; i < 40; i++) begin mosi = 1'($urandom); clks(2); sck = ~sck; end
    sck = 0; clks(4);
    comparePage("R12 idle toggles", 9'h0A0);
    wel = 1; runTxn("R12 after toggles", 8'h02, 8'hA3, 2, 0, 0);

    // random mix
    for (int it = 0; it < 36; it++) begin
      logic [7:0] op;
      int r;
      r = $urandom_range(0, 9);
      op = (r == 0) ? 8'($urandom) : {4'b0000, 1'($urandom), 3'b010};
      wel = ($urandom_range(0, 4) != 0);
      wpN = ($urandom_range(0, 5) != 0);
      bp  = ($urandom_range(0, 2) == 0) ? 2'($urandom) : 2'b00;
      runTxn("R4 R5 R8 random", op, 8'($urandom), $urandom_range(0, 18),
             ($urandom_range(0, 4) == 0) ? $urandom_range(1, 7) : 0, 0);
    end
    wpN = 1; bp = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule